// File: doc/BRIEF.md
# Pulse-Filtered Transparent Latch

This block models a level-sensitive data latch inside a fast sampling clock domain. Four raw inputs (data, enable, an asynchronous force-to-one and an asynchronous force-to-zero) each pass through their own qualification filter. A filter passes a new level on only after the raw input has held that level for a programmed number of sample cycles, so glitches shorter than that window never reach the latch. All timing is counted in sample cycles of `clk`.

The qualified levels drive a latch core. While the qualified enable is active, the stored value follows the qualified data. While it is inactive, the stored value holds. The two forcing inputs override enable and data. When both forcing inputs are active together, the result is an explicit unknown value. The stored value and its complement are reported on 2-bit logic-value ports. The active level of the enable is a parameter, and so is the active level of the forcing pair. The state after reset is a parameter too.

Top module: `pulse_filt_latch`

## Requirements
- R1: While the qualified enable is active and neither forcing input is qualified active, `q_o` equals the qualified data, with 0 encoded as 2'b00 and 1 encoded as 2'b01.
- R2: While the qualified enable is inactive and neither forcing input is qualified active, `q_o` keeps its previous value whatever the data input does.
- R3: A qualified active force-one input alone drives `q_o` to 2'b01, and a qualified active force-zero input alone drives it to 2'b00, regardless of enable and data.
- R4: When both forcing inputs are qualified active at once, `q_o` is the unknown code 2'b10.
- R5: A raw input level that is held for fewer sample edges than that input's delay parameter (`DATA_DLY`, `EN_DLY`, `SET_DLY`, `CLR_DLY`, each at least 1) has no effect on the outputs. A level held for exactly that many edges is accepted, and its effect shows on `q_o` right after the edge that completes the count.
- R6: With `EN_ACT_HIGH` = 1 the enable is active when high; with 0 it is active when low.
- R7: With `ASYNC_ACT_HIGH` = 1 both forcing inputs are active when high; with 0 they are active when low.
- R8: During and right after synchronous reset, `q_o` equals the `INIT_STATE` code: 0 gives 2'b00, 1 gives 2'b01, and 2 gives the unknown code 2'b10.
- R9: `qn_o` is always the complement of `q_o`: 2'b00 pairs with 2'b01, and 2'b10 pairs with 2'b10. The code 2'b11 never appears on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; every filter count and state update happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 1 | Raw data level |
| en_i | input | 1 | Raw enable level; its active level is set by `EN_ACT_HIGH` |
| set_i | input | 1 | Raw force-to-one request; its active level is set by `ASYNC_ACT_HIGH` |
| clr_i | input | 1 | Raw force-to-zero request; its active level is set by `ASYNC_ACT_HIGH` |
| q_o | output | 2 | Stored logic value (00 zero, 01 one, 10 unknown) |
| qn_o | output | 2 | Complement of `q_o` in the same encoding |

## Verification
A raw change that the bench drives before rising edge k becomes the qualified level at edge k+DLY-1 of that input's filter. The latch output follows that qualified level combinationally, so `q_o` settles right after that edge. The bench drives its inputs on falling edges. Each vector then waits a stated number of falling edges before it compares, so every comparison falls a whole half period after the last edge that could move the output. Boundary vectors stop exactly one edge short of the delay and then exactly on it, which pins the latency to the cycle. Glitch vectors restore the idle level before the count completes, and the held output is compared afterwards.

// File: rtl/pfl_pkg.sv
`timescale 1ns/1ps
package pfl_pkg;

    // three-valued logic level carried on the outputs
    typedef enum logic [1:0] {
        LV_ZERO = 2'b00,
        LV_ONE  = 2'b01,
        LV_UNK  = 2'b10
    } lv_e;

    localparam int N_IN = 4;

    // qualified input levels, bit order matches the raw vector in the top
    typedef struct packed {
        logic clr;
        logic set;
        logic en;
        logic data;
    } lvl_s;

    function automatic lv_e lv_inv(input lv_e v);
        case (v)
            LV_ZERO: return LV_ONE;
            LV_ONE:  return LV_ZERO;
            default: return LV_UNK;
        endcase
    endfunction

    function automatic lv_e lv_of_bit(input logic b);
        return b ? LV_ONE : LV_ZERO;
    endfunction

    function automatic lv_e lv_of_code(input logic [1:0] c);
        case (c)
            2'd0:    return LV_ZERO;
            2'd1:    return LV_ONE;
            default: return LV_UNK;
        endcase
    endfunction

endpackage

// File: rtl/pfl_filter.sv
`timescale 1ns/1ps
module pfl_filter #(
    parameter int DLY  = 1,
    parameter bit IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int            CW    = $clog2(DLY + 1);
    localparam logic [CW-1:0] DLY_C = CW'(DLY);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic          last_q;
    logic          lvl_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_n;

    // count of consecutive edges that sampled the current raw level
    always_comb begin
        if (raw_i != last_q)
            cnt_n = ONE_C;
        else if (cnt_q >= DLY_C)
            cnt_n = cnt_q;
        else
            cnt_n = cnt_q + ONE_C;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IDLE;
            cnt_q  <= DLY_C;
            lvl_q  <= IDLE;
        end else begin
            last_q <= raw_i;
            cnt_q  <= cnt_n;
            if (cnt_n >= DLY_C)
                lvl_q <= raw_i;
        end
    end

    assign lvl_o = lvl_q;

    // R5
    flt_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= ONE_C) && (cnt_q <= DLY_C));

    // R5
    flt_accept_src_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(raw_i)));

    // R5
    flt_no_early_chk: assert property (@(posedge clk) disable iff (rst)
        ((DLY > 1) && (lvl_q != $past(lvl_q))) |-> ($past(raw_i) == $past(last_q)));

endmodule

// File: rtl/pfl_core.sv
`timescale 1ns/1ps
module pfl_core
    import pfl_pkg::*;
#(
    parameter bit         EN_ACT_HIGH    = 1'b1,
    parameter bit         ASYNC_ACT_HIGH = 1'b1,
    parameter logic [1:0] INIT_STATE     = 2'd2
) (
    input  logic clk,
    input  logic rst,
    input  lvl_s lvl_i,
    output lv_e  q_o,
    output lv_e  qn_o
);
    localparam lv_e INIT_LV = lv_of_code(INIT_STATE);

    logic en_act;
    logic set_act;
    logic clr_act;
    lv_e  hold_q;
    lv_e  cur;

    assign en_act  = (lvl_i.en  == EN_ACT_HIGH);
    assign set_act = (lvl_i.set == ASYNC_ACT_HIGH);
    assign clr_act = (lvl_i.clr == ASYNC_ACT_HIGH);

    // forcing pair overrides the transparent path
    always_comb begin
        if (set_act && clr_act)
            cur = LV_UNK;
        else if (set_act)
            cur = LV_ONE;
        else if (clr_act)
            cur = LV_ZERO;
        else if (en_act)
            cur = lv_of_bit(lvl_i.data);
        else
            cur = hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= INIT_LV;
        else
            hold_q <= cur;
    end

    assign q_o  = cur;
    assign qn_o = lv_inv(cur);

    // R1
    follow_data_chk: assert property (@(posedge clk) disable iff (rst)
        (en_act && !set_act && !clr_act) |=>
            (hold_q == ($past(lvl_i.data) ? LV_ONE : LV_ZERO)));

    // R2
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_act && !set_act && !clr_act && $past(!en_act && !set_act && !clr_act))
            |-> $stable(q_o));

    // R3
    force_one_chk: assert property (@(posedge clk) disable iff (rst)
        (set_act && !clr_act) |=> (hold_q == LV_ONE));

    // R3
    force_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_act && !set_act) |=> (hold_q == LV_ZERO));

    // R4
    both_force_unk_chk: assert property (@(posedge clk) disable iff (rst)
        (set_act && clr_act) |=> (hold_q == LV_UNK));

endmodule

// File: rtl/pulse_filt_latch.sv
`timescale 1ns/1ps
module pulse_filt_latch
    import pfl_pkg::*;
#(
    parameter int         DATA_DLY       = 3,
    parameter int         EN_DLY         = 2,
    parameter int         SET_DLY        = 2,
    parameter int         CLR_DLY        = 4,
    parameter bit         EN_ACT_HIGH    = 1'b1,
    parameter bit         ASYNC_ACT_HIGH = 1'b1,
    parameter logic [1:0] INIT_STATE     = 2'd2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       data_i,
    input  logic       en_i,
    input  logic       set_i,
    input  logic       clr_i,
    output logic [1:0] q_o,
    output logic [1:0] qn_o
);
    localparam int         DLY_TAB [N_IN] = '{DATA_DLY, EN_DLY, SET_DLY, CLR_DLY};
    localparam logic [N_IN-1:0] IDLE_V = {~ASYNC_ACT_HIGH, ~ASYNC_ACT_HIGH, ~EN_ACT_HIGH, 1'b0};

    logic [N_IN-1:0] raw_v;
    logic [N_IN-1:0] lvl_v;
    lvl_s            lvl;
    lv_e             q_lv;
    lv_e             qn_lv;

    assign raw_v = {clr_i, set_i, en_i, data_i};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_flt
        pfl_filter #(
            .DLY  (DLY_TAB[gi]),
            .IDLE (IDLE_V[gi])
        ) u_flt (
            .clk   (clk),
            .rst   (rst),
            .raw_i (raw_v[gi]),
            .lvl_o (lvl_v[gi])
        );
    end

    assign lvl = lvl_s'(lvl_v);

    pfl_core #(
        .EN_ACT_HIGH    (EN_ACT_HIGH),
        .ASYNC_ACT_HIGH (ASYNC_ACT_HIGH),
        .INIT_STATE     (INIT_STATE)
    ) u_core (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (lvl),
        .q_o   (q_lv),
        .qn_o  (qn_lv)
    );

    assign q_o  = q_lv;
    assign qn_o = qn_lv;

    // R9
    compl_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ((q_o == 2'b00) == (qn_o == 2'b01)) && ((q_o == 2'b10) == (qn_o == 2'b10)));

    // R9
    no_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (q_o != 2'b11) && (qn_o != 2'b11));

    // R8
    init_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (q_o == ((INIT_STATE > 2'd1) ? 2'b10 : INIT_STATE)));

endmodule

// File: tb/sim_pulse_filt_latch.sv
`timescale 1ns/1ps
module sim_pulse_filt_latch;

    localparam realtime TCLK  = 20ns;
    localparam int      NVEC  = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;

    // u0: default parameters (delays 3/2/2/4, active high, unknown at reset)
    logic       d0 = 1'b0, e0 = 1'b0, s0 = 1'b0, c0 = 1'b0;
    logic [1:0] q0, qn0;
    // u1: active-low enable and forcing pair, zero at reset, delay 1 everywhere
    logic       d1 = 1'b0, e1 = 1'b1, s1 = 1'b1, c1 = 1'b1;
    logic [1:0] q1, qn1;

    int n_chk  = 0;
    int n_fail = 0;

    always #(TCLK/2) clk = ~clk;

    pulse_filt_latch u0 (
        .clk(clk), .rst(rst), .data_i(d0), .en_i(e0), .set_i(s0), .clr_i(c0),
        .q_o(q0), .qn_o(qn0)
    );

    pulse_filt_latch #(
        .DATA_DLY(1), .EN_DLY(1), .SET_DLY(1), .CLR_DLY(1),
        .EN_ACT_HIGH(1'b0), .ASYNC_ACT_HIGH(1'b0), .INIT_STATE(2'd0)
    ) u1 (
        .clk(clk), .rst(rst), .data_i(d1), .en_i(e1), .set_i(s1), .clr_i(c1),
        .q_o(q1), .qn_o(qn1)
    );

    function automatic logic [1:0] exp_inv(input logic [1:0] v);
        return (v == 2'b00) ? 2'b01 : (v == 2'b01) ? 2'b00 : 2'b10;
    endfunction

    task automatic check(input string tag, input logic [1:0] q, input logic [1:0] qn,
                         input logic [1:0] exp);
        n_chk++;
        if (q !== exp || qn !== exp_inv(exp)) begin
            n_fail++;
            $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b", tag, q, qn, exp, exp_inv(exp));
        end
    endtask

    // row: requirement number, {data,en,set,clr}, falling edges to wait, expected q
    localparam logic [13:0] VEC [NVEC] = '{
        {4'd2, 4'b1000, 4'd5, 2'b10},  // R2 enable idle, unknown held
        {4'd1, 4'b1100, 4'd5, 2'b01},  // R1 transparent, data 1
        {4'd5, 4'b0100, 4'd2, 2'b01},  // R5 data change, one edge short
        {4'd5, 4'b0100, 4'd1, 2'b00},  // R5 data accepted on its third edge
        {4'd5, 4'b1100, 4'd2, 2'b00},  // R5 data glitch of two edges
        {4'd5, 4'b0100, 4'd4, 2'b00},  // R5 glitch ignored
        {4'd1, 4'b1100, 4'd4, 2'b01},  // R1 data 1 again
        {4'd2, 4'b1000, 4'd3, 2'b01},  // R2 enable closes
        {4'd2, 4'b0000, 4'd5, 2'b01},  // R2 data moves while closed
        {4'd3, 4'b0001, 4'd4, 2'b00},  // R3 force-zero on its fourth edge
        {4'd2, 4'b0000, 4'd5, 2'b00},  // R2 hold after release
        {4'd5, 4'b0010, 4'd1, 2'b00},  // R5 force-one glitch of one edge
        {4'd5, 4'b0000, 4'd3, 2'b00},  // R5 glitch ignored
        {4'd3, 4'b0010, 4'd2, 2'b01},  // R3 force-one on its second edge
        {4'd3, 4'b0110, 4'd5, 2'b01},  // R3 force-one beats enable with data 0
        {4'd4, 4'b0111, 4'd4, 2'b10},  // R4 both forcing inputs active
        {4'd1, 4'b0100, 4'd5, 2'b00},  // R1 release, transparent data 0
        {4'd1, 4'b1100, 4'd5, 2'b01},  // R1 data 1
        {4'd2, 4'b1000, 4'd5, 2'b01},  // R2 closed
        {4'd5, 4'b1001, 4'd3, 2'b01},  // R5 force-zero one edge short
        {4'd3, 4'b1001, 4'd1, 2'b00},  // R3 force-zero accepted on fourth edge
        {4'd2, 4'b0000, 4'd6, 2'b00}   // R2 quiet hold
    };

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8 reset state: u0 unknown, u1 zero
        check("R8 u0 init", q0, qn0, 2'b10);
        check("R8 u1 init", q1, qn1, 2'b00);
        repeat (3) @(negedge clk);
        check("R8 u0 after idle", q0, qn0, 2'b10);

        for (int i = 0; i < NVEC; i++) begin
            {d0, e0, s0, c0} = VEC[i][9:6];
            repeat (int'(VEC[i][5:2])) @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][13:10], i), q0, qn0, VEC[i][1:0]);
        end

        // R6 active-low enable: low opens the latch
        d1 = 1'b1; e1 = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 low enable follows", q1, qn1, 2'b01);
        e1 = 1'b1; d1 = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 high enable holds", q1, qn1, 2'b01);
        // R7 active-low forcing pair
        c1 = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 low force-zero", q1, qn1, 2'b00);
        c1 = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 high force-zero idle", q1, qn1, 2'b00);
        s1 = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 low force-one", q1, qn1, 2'b01);
        c1 = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 both low forcing", q1, qn1, 2'b10);
        s1 = 1'b1; c1 = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 unknown held with complement", q1, qn1, 2'b10);

        // R8 reset mid-run restores the init code
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R8 u0 re-init", q0, qn0, 2'b10);
        check("R8 u1 re-init", q1, qn1, 2'b00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(TCLK * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule